// File: doc/BRIEF.md
# Oversampled Serial Receiver with Holding Buffer and Sticky Error Flags

This block recovers characters from an asynchronous serial line. It uses a clock enable that pulses sixteen times per bit period. When the line falls while idle, the receiver checks the line again at the middle of the start bit. A start that does not last to that point is treated as noise and ignored. Once a start bit is confirmed, the receiver samples each data bit at its centre, least significant bit first. It then samples the optional parity bit and the first stop bit. Only the data bits are delivered to the host, in parallel and right-aligned.

The character is built in a shift register and moved to a separate holding buffer when it completes. The host can therefore read one character while the next one is still arriving. A data-ready flag marks an unread character in the buffer. Three status flags report a bad parity bit, a low stop bit, and a character that arrived while the previous one was still unread. The error flags stay set until the host pulses the error-clear input. The character length and the parity mode are shared with the matching transmitter and come in as static configuration.

Top module: `serial_rx_dbuf`

## Requirements
- R1: After reset, `data_ready`, `par_err`, `frm_err` and `ovr_err` are 0 and `rx_data` is 0.
- R2: A low on the idle line that is high again at the mid-start check (8 enables after the low is first seen) starts no character: `data_ready` and all flags stay 0.
- R3: Data bits are taken LSB first, one per bit period at the bit centre. `cfg_len` selects the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Buffer bits above the character length read as 0.
- R4: With `cfg_par_en`=1, one parity bit follows the data. With `cfg_par_odd`=0 the count of ones in the data plus the parity bit must be even; with 1 it must be odd. A mismatch sets `par_err`.
- R5: With `cfg_par_en`=0, no parity bit is expected, the stop bit directly follows the data, and `par_err` never sets.
- R6: A low sample at the centre of the first stop bit sets `frm_err`. The data of that character is still delivered.
- R7: Each completed character sets `data_ready`. A one-cycle `rd_strobe` clears it.
- R8: A character that completes while `data_ready` is still 1 sets `ovr_err` and replaces the buffer contents with the new character.
- R9: `par_err`, `frm_err` and `ovr_err` stay set until a one-cycle `err_clr` clears all three. `err_clr` leaves `data_ready` and `rx_data` unchanged.
- R10: While a new character is being shifted in, `rx_data` keeps the previous character. Reading the buffer during that time avoids an overrun when the new character completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulse, sixteen per bit period |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_len | input | 2 | Character length code (5 to 8 bits) |
| cfg_par_en | input | 1 | 1: a parity bit is expected |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| rd_strobe | input | 1 | Host read of the holding buffer |
| err_clr | input | 1 | Clears the three error flags |
| rx_data | output | 8 | Holding buffer, data right-aligned |
| data_ready | output | 1 | Unread character in the buffer |
| par_err | output | 1 | Sticky parity error |
| frm_err | output | 1 | Sticky framing error |
| ovr_err | output | 1 | Sticky overrun error |

## Verification
The bench sends a short low glitch. A receiver that skips the mid-start check would frame garbage and raise `data_ready`. It sends 5-bit characters whose upper bits are set in the source value. A receiver with a wrong length decode or an uncleared shift register would show stray upper bits. It uses parity-none with a deliberately "wrong" bit pattern, which catches a receiver that still samples and checks a parity slot. It also sends a second character while the first is unread, and reads the buffer in the middle of a character. Together these separate a single-register receiver, which would corrupt the waiting data or report false overruns, from a correct double-buffered one.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  localparam int DATA_W = 8;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int LEN_W  = 2;
  localparam int MIN_BITS = 5;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_t;

  // index of the last data bit for a length code
  function automatic logic [IDX_W-1:0] last_bit_idx(input logic [LEN_W-1:0] len);
    return IDX_W'(MIN_BITS - 1) + IDX_W'(len);
  endfunction

  // mask of the valid data bits for a length code
  function automatic logic [DATA_W-1:0] len_mask(input logic [LEN_W-1:0] len);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) begin
      m[i] = (i <= int'(last_bit_idx(len)));
    end
    return m;
  endfunction

  // parity bit a sender would attach to the data
  function automatic logic expected_parity(input logic [DATA_W-1:0] d,
                                           input logic odd);
    return (^d) ^ odd;
  endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer
  import serial_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 line_s,
  input  logic [LEN_W-1:0]     cfg_len,
  input  logic                 cfg_par_en,
  input  logic                 cfg_par_odd,
  output logic                 done,
  output logic [DATA_W-1:0]    done_data,
  output logic                 done_par_bad,
  output logic                 done_stop_bad
);
  localparam int PH_W = $clog2(OVS);
  localparam logic [PH_W-1:0] MID_PH  = PH_W'(OVS/2 - 1);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(OVS - 1);

  rx_state_t           state;
  logic [PH_W-1:0]     phase;
  logic [IDX_W-1:0]    bit_idx;
  logic [DATA_W-1:0]   shreg;
  logic                par_bit;
  logic                armed;
  logic                at_centre;

  assign at_centre = tick && (phase == LAST_PH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= RX_IDLE;
      phase         <= '0;
      bit_idx       <= '0;
      shreg         <= '0;
      par_bit       <= 1'b0;
      armed         <= 1'b0;
      done          <= 1'b0;
      done_data     <= '0;
      done_par_bad  <= 1'b0;
      done_stop_bad <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        unique case (state)
          RX_IDLE: begin
            if (!line_s && armed) begin
              state <= RX_START;
              phase <= '0;
              armed <= 1'b0;
            end else if (line_s) begin
              armed <= 1'b1;
            end
          end
          RX_START: begin
            if (phase == MID_PH) begin
              if (!line_s) begin
                state   <= RX_DATA;
                phase   <= '0;
                bit_idx <= '0;
                shreg   <= '0;
              end else begin
                state <= RX_IDLE;
                armed <= 1'b1;
              end
            end else begin
              phase <= phase + 1'b1;
            end
          end
          RX_DATA: begin
            phase <= phase + 1'b1;
            if (at_centre) begin
              shreg[bit_idx] <= line_s;
              if (bit_idx == last_bit_idx(cfg_len)) begin
                state <= cfg_par_en ? RX_PAR : RX_STOP;
              end else begin
                bit_idx <= bit_idx + 1'b1;
              end
            end
          end
          RX_PAR: begin
            phase <= phase + 1'b1;
            if (at_centre) begin
              par_bit <= line_s;
              state   <= RX_STOP;
            end
          end
          RX_STOP: begin
            phase <= phase + 1'b1;
            if (at_centre) begin
              done          <= 1'b1;
              done_data     <= shreg & len_mask(cfg_len);
              done_par_bad  <= cfg_par_en &&
                               (expected_parity(shreg, cfg_par_odd) != par_bit);
              done_stop_bad <= !line_s;
              state         <= RX_IDLE;
              armed         <= line_s;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_rx_holdbuf.sv
module serial_rx_holdbuf
  import serial_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_par_bad,
  input  logic              load_stop_bad,
  input  logic              rd,
  input  logic              clr,
  output logic [DATA_W-1:0] buf_data,
  output logic              ready,
  output logic              pe,
  output logic              fe,
  output logic              oe
);
  logic overrun_evt;

  // a load that finds unread data counts as overrun unless it is read now
  assign overrun_evt = load && ready && !rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_data <= '0;
      ready    <= 1'b0;
    end else if (load) begin
      buf_data <= load_data;
      ready    <= 1'b1;
    end else if (rd) begin
      ready    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe <= 1'b0;
      fe <= 1'b0;
      oe <= 1'b0;
    end else begin
      pe <= (pe && !clr) || (load && load_par_bad);
      fe <= (fe && !clr) || (load && load_stop_bad);
      oe <= (oe && !clr) || overrun_evt;
    end
  end
endmodule

// File: rtl/serial_rx_dbuf.sv
module serial_rx_dbuf
  import serial_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rx_line,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              rd_strobe,
  input  logic              err_clr,
  output logic [7:0]        rx_data,
  output logic              data_ready,
  output logic              par_err,
  output logic              frm_err,
  output logic              ovr_err
);
  // internal events, named for the checker
  logic              line_s;
  logic              rx_done;
  logic [DATA_W-1:0] rx_done_data;
  logic              rx_done_par_bad;
  logic              rx_done_stop_bad;

  serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (rx_line),
    .dout  (line_s)
  );

  serial_rx_framer #(.OVS(OVS)) u_framer (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick16),
    .line_s        (line_s),
    .cfg_len       (cfg_len),
    .cfg_par_en    (cfg_par_en),
    .cfg_par_odd   (cfg_par_odd),
    .done          (rx_done),
    .done_data     (rx_done_data),
    .done_par_bad  (rx_done_par_bad),
    .done_stop_bad (rx_done_stop_bad)
  );

  serial_rx_holdbuf u_buf (
    .clk           (clk),
    .rst_n         (rst_n),
    .load          (rx_done),
    .load_data     (rx_done_data),
    .load_par_bad  (rx_done_par_bad),
    .load_stop_bad (rx_done_stop_bad),
    .rd            (rd_strobe),
    .clr           (err_clr),
    .buf_data      (rx_data),
    .ready         (data_ready),
    .pe            (par_err),
    .fe            (frm_err),
    .oe            (ovr_err)
  );
endmodule

// File: rtl/serial_rx_dbuf_chk.sv
module serial_rx_dbuf_chk
  import serial_rx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cfg_len,
  input logic              cfg_par_en,
  input logic              rd_strobe,
  input logic              err_clr,
  input logic [7:0]        rx_data,
  input logic              data_ready,
  input logic              par_err,
  input logic              frm_err,
  input logic              ovr_err,
  input logic              rx_done,
  input logic              rx_done_par_bad
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> !data_ready && !par_err && !frm_err && !ovr_err);

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> (rx_data & ~len_mask($past(cfg_len))) == '0);

  assert_no_par_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !cfg_par_en) |-> !rx_done_par_bad);

  assert_ready_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> data_ready);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !rx_done) |=> !data_ready);

  assert_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && data_ready && !rd_strobe) |=> ovr_err);

  assert_sticky_pe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !err_clr) |=> par_err);

  assert_sticky_fe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_err && !err_clr) |=> frm_err);

  assert_sticky_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err && !err_clr) |=> ovr_err);

  assert_buffer_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |=> $stable(rx_data));
endmodule

bind serial_rx_dbuf serial_rx_dbuf_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cfg_len         (cfg_len),
  .cfg_par_en      (cfg_par_en),
  .rd_strobe       (rd_strobe),
  .err_clr         (err_clr),
  .rx_data         (rx_data),
  .data_ready      (data_ready),
  .par_err         (par_err),
  .frm_err         (frm_err),
  .ovr_err         (ovr_err),
  .rx_done         (rx_done),
  .rx_done_par_bad (rx_done_par_bad)
);

// File: tb/tb_serial_rx_dbuf.sv
module tb_serial_rx_dbuf;
  localparam int TDIV    = 4;
  localparam int BIT_CLK = 16 * TDIV;
  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16;
  logic       rx_line = 1'b1;
  logic [1:0] cfg_len = 2'b11;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       rd_strobe = 1'b0;
  logic       err_clr = 1'b0;
  logic [7:0] rx_data;
  logic       data_ready, par_err, frm_err, ovr_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int tcnt = 0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) begin
    tcnt   <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
    cycles <= cycles + 1;
  end
  assign tick16 = (tcnt == TDIV - 1);

  serial_rx_dbuf dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_line(rx_line),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .rd_strobe(rd_strobe), .err_clr(err_clr), .rx_data(rx_data),
    .data_ready(data_ready), .par_err(par_err), .frm_err(frm_err),
    .ovr_err(ovr_err)
  );

  typedef struct packed {
    logic [1:0] len;
    logic       pen;
    logic       odd;
    logic [7:0] data;
    logic       flip_par;
    logic       low_stop;
    logic [7:0] exp_data;
    logic       exp_pe;
    logic       exp_fe;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{2'b11, 1'b1, 1'b0, 8'hA5, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},
    '{2'b11, 1'b1, 1'b1, 8'h3C, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b0},
    '{2'b00, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 8'h1F, 1'b0, 1'b0},
    '{2'b01, 1'b1, 1'b1, 8'h2A, 1'b0, 1'b0, 8'h2A, 1'b0, 1'b0},
    '{2'b10, 1'b0, 1'b0, 8'h55, 1'b0, 1'b1, 8'h55, 1'b0, 1'b1},
    '{2'b11, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0},
    '{2'b10, 1'b1, 1'b0, 8'h7F, 1'b1, 1'b0, 8'h7F, 1'b1, 1'b0},
    '{2'b00, 1'b1, 1'b1, 8'h13, 1'b0, 1'b0, 8'h13, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold_bits(input int n);
    repeat (n * BIT_CLK) @(negedge clk);
  endtask

  // send one character in the current configuration
  task automatic send(input logic [7:0] d, input logic flip_par,
                      input logic low_stop);
    int nb;
    logic p;
    nb = 5 + int'(cfg_len);
    p = 1'b0;
    for (int i = 0; i < nb; i++) p = p ^ d[i];
    p = p ^ cfg_par_odd ^ flip_par;
    rx_line = 1'b0;
    hold_bits(1);
    for (int i = 0; i < nb; i++) begin
      rx_line = d[i];
      hold_bits(1);
    end
    if (cfg_par_en) begin
      rx_line = p;
      hold_bits(1);
    end
    rx_line = !low_stop;
    hold_bits(1);
    rx_line = 1'b1;
    hold_bits(1);
  endtask

  task automatic pulse_rd();
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
  endtask

  initial begin
    while (cycles < WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 ready", data_ready, 0);
    check("R1 flags", {par_err, frm_err, ovr_err}, 0);
    check("R1 data", rx_data, 0);
    rst_n = 1'b1;
    hold_bits(2);

    // table-driven: R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      cfg_len = VEC[v].len;
      cfg_par_en = VEC[v].pen;
      cfg_par_odd = VEC[v].odd;
      hold_bits(1);
      send(VEC[v].data, VEC[v].flip_par, VEC[v].low_stop);
      check("R7 ready after char", data_ready, 1);
      check("R3 data", rx_data, VEC[v].exp_data);
      check(VEC[v].pen ? "R4 parity" : "R5 parity none", par_err, VEC[v].exp_pe);
      check("R6 framing", frm_err, VEC[v].exp_fe);
      check("R8 no overrun", ovr_err, 0);
      pulse_rd();
      check("R7 read clears", data_ready, 0);
      pulse_clr();
      check("R9 clear", {par_err, frm_err, ovr_err}, 0);
    end

    // R2 noise on the start bit
    cfg_len = 2'b11; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    rx_line = 1'b0;
    repeat (3 * TDIV) @(negedge clk);
    rx_line = 1'b1;
    hold_bits(12);
    check("R2 glitch ignored ready", data_ready, 0);
    check("R2 glitch ignored flags", {par_err, frm_err, ovr_err}, 0);

    // R8 overrun: second char without a read
    send(8'h11, 1'b0, 1'b0);
    send(8'h22, 1'b0, 1'b0);
    check("R8 overrun flag", ovr_err, 1);
    check("R8 overwrite", rx_data, 8'h22);
    // R9 sticky across a clean char and through a read
    pulse_rd();
    send(8'h33, 1'b0, 1'b0);
    check("R9 overrun sticky", ovr_err, 1);
    pulse_clr();
    check("R9 clear overrun", ovr_err, 0);
    check("R9 clear keeps ready", data_ready, 1);
    check("R9 clear keeps data", rx_data, 8'h33);
    pulse_rd();

    // R9 parity error stays set over a good character
    cfg_par_en = 1'b1;
    send(8'h0F, 1'b1, 1'b0);
    pulse_rd();
    send(8'hF1, 1'b0, 1'b0);
    check("R9 parity sticky", par_err, 1);
    check("R4 good char data", rx_data, 8'hF1);
    pulse_clr();
    pulse_rd();
    cfg_par_en = 1'b0;

    // R10 read in the middle of the next character
    send(8'h5A, 1'b0, 1'b0);
    fork
      send(8'hC3, 1'b0, 1'b0);
      begin
        hold_bits(4);
        check("R10 old data held", rx_data, 8'h5A);
        pulse_rd();
      end
    join
    check("R10 new data", rx_data, 8'hC3);
    check("R10 ready", data_ready, 1);
    check("R10 no overrun", ovr_err, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule